// File: doc/BRIEF.md
# I2C Target Byte Engine

This block is the target side of an I2C bus, seen by a processor as a data register, a four-bit control word and a set of status flags. It watches the open-drain clock and data lines, and it recognizes START and STOP conditions. It compares the first byte after every START with two programmable 7-bit own addresses. It can also compare that byte with the general call address. When an address matches and is acknowledged, the engine takes the transfer direction from bit 0 of that byte. It then serves bytes one at a time.

After each acknowledged address or data byte, the engine makes its active-low pending flag active and holds SCL low until software services the data register. In receive direction, software reads the byte, and the read releases the clock. In transmit direction, software writes the next byte, and the write releases the clock. The engine also reports bus errors and STOP conditions made by the external controller. One interrupt line collects the pending, error and STOP events.

Top module: `i2c_target_port`

## Requirements
- R1: After a START, an address byte whose upper seven bits equal `own_addr_a` or `own_addr_b` is acknowledged (SDA held low in the ninth clock) and sets `aas`; any other address is not acknowledged and leaves `aas` at 0 and `pend_n` at 1.
- R2: The all-zero address byte is treated as a match while `gcall_off` is 0 and is not acknowledged while `gcall_off` is 1.
- R3: Bit 0 of a matched address byte sets the direction: 1 makes `trx` 1 (block transmits), 0 makes `trx` 0 (block receives).
- R4: When the ninth clock of an acknowledged address or data byte falls, `pend_n` becomes 0 and `scl_oe` holds SCL low until the data register is serviced.
- R5: In receive direction `dat_rdata` shows the last byte received (the address byte right after the address phase); pulsing `dat_rd` releases SCL, and a pulse on either `dat_rd` or `dat_wr` returns `pend_n` to 1.
- R6: With control bit 1 (acknowledge enable) at 0, a received byte is not acknowledged. A matching address is then ignored and `aas` stays 0. A data byte is still captured in `dat_rdata` with `pend_n` 0, but SCL is not held.
- R7: In transmit direction, the byte written through `dat_wr` is shifted out MSB first. `lrb` records the controller's acknowledge bit (1 = not acknowledged). After a not-acknowledge, SCL is not held, and the following write clears `pend_n` without driving SDA.
- R8: A control write with bit 3 set clears `pend_n` to 1 and clears `aas`, `lrb`, `ber` and `ext_stop`. It also returns the engine to idle and releases SCL, and it leaves `nbb` unchanged.
- R9: With control bit 2 (output enable) at 0, `scl_oe` and `sda_oe` stay 0 and no address is acknowledged.
- R10: `irq` equals control bit 0 (interrupt enable) ANDed with the OR of (`pend_n` == 0), `ber` and `ext_stop`.
- R11: `nbb` goes to 0 on a START and to 1 on a STOP. While output enable is 1, a STOP sets `ext_stop`.
- R12: A START or STOP that arrives once two or more clocks of an address or data byte have risen sets `ber`, and the engine drops the transfer.
- R13: After reset, `pend_n` and `nbb` are 1, and `aas`, `ber`, `ext_stop`, `irq`, `scl_oe` and `sda_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr_a | input | 7 | First own address |
| own_addr_b | input | 7 | Second own address |
| gcall_off | input | 1 | 1 disables general call match |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Control: [0] irq enable, [1] ack enable, [2] output enable, [3] clear status |
| dat_rd | input | 1 | Data register read strobe |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rdata | output | 8 | Last byte received |
| pend_n | output | 1 | Service pending, active low |
| nbb | output | 1 | Bus not busy |
| aas | output | 1 | Own address matched |
| trx | output | 1 | Transmit direction |
| lrb | output | 1 | Last acknowledge bit from controller |
| ber | output | 1 | Bus error |
| ext_stop | output | 1 | STOP seen |
| irq | output | 1 | Interrupt |

## Verification
Random transactions pick one of the two own addresses, a random direction, lengths of one to three bytes and random data. Comparing the received and transmitted bytes separates the two address slots, both shift directions and the stretch-and-release handshake for each byte. Directed cases use a foreign address and the general call address with matching on and off, which separates a match from a miss. Further directed cases clear acknowledge enable, clear output enable, clear interrupt enable, place a STOP in the middle of a byte and write the status clear while the clock is held. Each of these cases changes exactly one output flag against the plain transfer.

// File: rtl/i2c_target_port.sv
module i2c_target_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [6:0] own_addr_a,
  input  logic [6:0] own_addr_b,
  input  logic       gcall_off,
  input  logic       ctrl_we,
  input  logic [3:0] ctrl_wdata,
  input  logic       dat_rd,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  output logic [7:0] dat_rdata,
  output logic       pend_n,
  output logic       nbb,
  output logic       aas,
  output logic       trx,
  output logic       lrb,
  output logic       ber,
  output logic       ext_stop,
  output logic       irq
);
  localparam int DW = 8;
  localparam logic [3:0] LAST_BIT = 4'(DW);
  localparam logic [3:0] MID_BYTE = 4'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_RX, S_RXACK, S_RXWAIT,
    S_TX, S_TXACK, S_TXWAIT, S_TXDONE
  } state_t;

  state_t state;
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_s, sda_s, scl_d, sda_d;
  logic start_c, stop_c, rise, fall, in_byte, match;
  logic [3:0] bitcnt;
  logic [DW-1:0] shreg, rx_q;
  logic ien, ack_en, eso, drive_ack;

  assign scl_s   = scl_sr[SYNC_STAGES-1];
  assign sda_s   = sda_sr[SYNC_STAGES-1];
  assign start_c = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  assign rise    = ~scl_d & scl_s;
  assign fall    = scl_d & ~scl_s;
  assign in_byte = (state == S_ADDR || state == S_RX || state == S_TX) && bitcnt >= MID_BYTE;
  assign match   = (shreg[7:1] == own_addr_a) || (shreg[7:1] == own_addr_b) ||
                   (shreg[7:1] == 7'd0 && !gcall_off);

  assign scl_oe    = eso && (state == S_RXWAIT || state == S_TXWAIT);
  assign sda_oe    = eso && (state == S_AACK || (state == S_RXACK && drive_ack) ||
                             (state == S_TX && !shreg[7]));
  assign dat_rdata = rx_q;
  assign irq       = ien && (!pend_n || ber || ext_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      rx_q      <= '0;
      drive_ack <= 1'b0;
      pend_n    <= 1'b1;
      nbb       <= 1'b1;
      aas       <= 1'b0;
      trx       <= 1'b0;
      lrb       <= 1'b0;
      ber       <= 1'b0;
      ext_stop  <= 1'b0;
      ien       <= 1'b0;
      ack_en    <= 1'b0;
      eso       <= 1'b0;
    end else begin
      if (start_c) nbb <= 1'b0;
      if (stop_c)  nbb <= 1'b1;
      if (stop_c && eso) ext_stop <= 1'b1;
      if (dat_rd || dat_wr) pend_n <= 1'b1;

      if (!eso) begin
        state <= S_IDLE;
      end else if ((start_c || stop_c) && in_byte) begin
        ber   <= 1'b1;
        state <= S_IDLE;
      end else if (start_c) begin
        state  <= S_ADDR;
        bitcnt <= '0;
      end else if (stop_c) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_ADDR, S_RX: begin
            if (rise) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (fall && bitcnt == LAST_BIT) begin
              if (state == S_ADDR) begin
                if (match && ack_en) begin
                  state <= S_AACK;
                  aas   <= 1'b1;
                  trx   <= shreg[0];
                  rx_q  <= shreg;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                rx_q      <= shreg;
                drive_ack <= ack_en;
                state     <= S_RXACK;
              end
            end
          end
          S_AACK: if (fall) begin
            pend_n <= 1'b0;
            state  <= trx ? S_TXWAIT : S_RXWAIT;
          end
          S_RXACK: if (fall) begin
            pend_n <= 1'b0;
            state  <= drive_ack ? S_RXWAIT : S_IDLE;
          end
          S_RXWAIT: if (dat_rd) begin
            state  <= S_RX;
            bitcnt <= '0;
          end
          S_TX: begin
            if (rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (fall) begin
              if (bitcnt == LAST_BIT) state <= S_TXACK;
              else shreg <= {shreg[DW-2:0], 1'b0};
            end
          end
          S_TXACK: begin
            if (rise) begin
              lrb <= sda_s;
            end else if (fall) begin
              pend_n <= 1'b0;
              state  <= lrb ? S_TXDONE : S_TXWAIT;
            end
          end
          S_TXWAIT: if (dat_wr) begin
            shreg  <= dat_wdata;
            bitcnt <= '0;
            state  <= S_TX;
          end
          S_TXDONE: if (dat_wr) state <= S_IDLE;
          default: ;
        endcase
      end

      if (ctrl_we) begin
        ien    <= ctrl_wdata[0];
        ack_en <= ctrl_wdata[1];
        eso    <= ctrl_wdata[2];
        if (ctrl_wdata[3]) begin
          pend_n   <= 1'b1;
          aas      <= 1'b0;
          lrb      <= 1'b0;
          ber      <= 1'b0;
          ext_stop <= 1'b0;
          state    <= S_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_target_port_chk.sv
module i2c_target_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_we,
  input logic [3:0] ctrl_wdata,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       pend_n,
  input logic       nbb,
  input logic       aas,
  input logic       lrb,
  input logic       ber,
  input logic       ext_stop,
  input logic       irq,
  input logic       scl_sync
);
  assert_match_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aas) |-> !nbb);

  assert_stretch_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !pend_n);

  assert_pending_clock_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_n) |-> !$past(scl_sync));

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && ctrl_wdata[3] |=> pend_n && !aas && !ber && !ext_stop && !lrb);

  assert_outputs_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && !ctrl_wdata[2] |=> !scl_oe && !sda_oe);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && !ctrl_wdata[0] |=> !irq);

  assert_error_releases_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ber) |-> !scl_oe && !sda_oe);
endmodule

bind i2c_target_port i2c_target_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .pend_n(pend_n), .nbb(nbb), .aas(aas),
  .lrb(lrb), .ber(ber), .ext_stop(ext_stop), .irq(irq), .scl_sync(scl_s)
);

// File: tb/test_i2c_target_port.sv
module test_i2c_target_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [6:0] OWN_A = 7'h52;
  localparam logic [6:0] OWN_B = 7'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_scl_low = 1'b0, ctl_sda_low = 1'b0;
  logic scl, sda, scl_oe, sda_oe;
  logic gcall_off = 1'b0;
  logic ctrl_we = 1'b0;
  logic [3:0] ctrl_wdata = '0;
  logic dat_rd = 1'b0, dat_wr = 1'b0;
  logic [7:0] dat_wdata = '0, dat_rdata;
  logic pend_n, nbb, aas, trx, lrb, ber, ext_stop, irq;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl = ~(ctl_scl_low | scl_oe);
  assign sda = ~(ctl_sda_low | sda_oe);

  i2c_target_port i_i2c_target_port (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .own_addr_a(OWN_A), .own_addr_b(OWN_B), .gcall_off(gcall_off),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .dat_rd(dat_rd), .dat_wr(dat_wr),
    .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .pend_n(pend_n), .nbb(nbb), .aas(aas),
    .trx(trx), .lrb(lrb), .ber(ber), .ext_stop(ext_stop), .irq(irq)
  );

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  function automatic logic exp_irq(input logic en, input logic pn, input logic be, input logic es);
    return en & (~pn | be | es);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic v, output logic s);
    ctl_sda_low = !v;
    hp();
    ctl_scl_low = 1'b0;
    while (!scl) @(negedge clk);
    hp();
    s = sda;
    ctl_scl_low = 1'b1;
    hp();
  endtask

  task automatic send_start();
    ctl_sda_low = 1'b1; hp();
    ctl_scl_low = 1'b1; hp();
  endtask

  task automatic send_stop();
    ctl_sda_low = 1'b1; hp();
    ctl_scl_low = 1'b0;
    while (!scl) @(negedge clk);
    hp();
    ctl_sda_low = 1'b0; hp();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    acked = !s;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      b[i] = s;
    end
    bit_xfer(!give_ack, s);
  endtask

  task automatic sw_read(output logic [7:0] d);
    @(negedge clk); d = dat_rdata; dat_rd = 1'b1;
    @(negedge clk); dat_rd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk); dat_wdata = d; dat_wr = 1'b1;
    @(negedge clk); dat_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ctrl_wr(input logic [3:0] v);
    @(negedge clk); ctrl_wdata = v; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d, b;
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 pend_n", pend_n, 1); chk("R13 nbb", nbb, 1); chk("R13 aas", aas, 0);
    chk("R13 ber", ber, 0); chk("R13 ext_stop", ext_stop, 0); chk("R13 irq", irq, 0);
    chk("R13 oe", {scl_oe, sda_oe}, 0);

    ctrl_wr(4'b1111);

    // R1 foreign address
    send_start();
    write_byte(addr_byte(7'h33, 1'b0), ack);
    chk("R1 foreign ack", ack, 0); chk("R1 foreign aas", aas, 0); chk("R1 foreign pend", pend_n, 1);
    send_stop(); ctrl_wr(4'b1111);

    // R2 general call on/off
    send_start();
    write_byte(8'h00, ack);
    chk("R2 gcall ack", ack, 1); chk("R2 gcall aas", aas, 1);
    sw_read(d); send_stop(); ctrl_wr(4'b1111);
    gcall_off = 1'b1;
    send_start();
    write_byte(8'h00, ack);
    chk("R2 gcall off ack", ack, 0); chk("R2 gcall off aas", aas, 0);
    send_stop(); ctrl_wr(4'b1111);

    // R6 acknowledge disabled
    ctrl_wr(4'b0101);
    send_start();
    write_byte(addr_byte(OWN_A, 1'b0), ack);
    chk("R6 addr nack", ack, 0); chk("R6 addr aas", aas, 0);
    send_stop(); ctrl_wr(4'b1111);
    send_start();
    write_byte(addr_byte(OWN_A, 1'b0), ack);
    ctrl_wr(4'b0101);
    sw_read(d);
    write_byte(8'hA5, ack);
    chk("R6 data nack", ack, 0); chk("R6 pend", pend_n, 0); chk("R6 no stretch", scl_oe, 0);
    chk("R6 data", dat_rdata, 8'hA5);
    chk("R10 irq pend", irq, exp_irq(1'b1, pend_n, ber, ext_stop));
    send_stop(); ctrl_wr(4'b1111);

    // R8 status clear while stretching
    send_start();
    write_byte(addr_byte(OWN_B, 1'b0), ack);
    chk("R4 stretch", {pend_n, scl_oe}, 2'b01);
    ctrl_wr(4'b1111);
    @(negedge clk);
    chk("R8 pend", pend_n, 1); chk("R8 aas", aas, 0); chk("R8 scl", scl_oe, 0); chk("R8 nbb kept", nbb, 0);
    send_stop(); ctrl_wr(4'b1111);

    // R12 STOP inside a byte
    send_start();
    write_byte(addr_byte(OWN_A, 1'b0), ack);
    sw_read(d);
    for (int i = 0; i < 3; i++) bit_xfer(1'b1, ack);
    send_stop();
    repeat (4) @(negedge clk);
    chk("R12 ber", ber, 1); chk("R10 irq ber", irq, 1);
    ctrl_wr(4'b1110);
    @(negedge clk);
    chk("R8 ber cleared", ber, 0); chk("R10 irq masked", irq, 0);

    // R10 interrupt disabled with pending active
    send_start();
    write_byte(addr_byte(OWN_A, 1'b0), ack);
    chk("R10 pend", pend_n, 0); chk("R10 irq off", irq, 0);
    sw_read(d); send_stop(); ctrl_wr(4'b1111);

    // R9 outputs disabled
    ctrl_wr(4'b1011);
    send_start();
    chk("R11 nbb start", nbb, 0);
    write_byte(addr_byte(OWN_A, 1'b0), ack);
    chk("R9 no ack", ack, 0); chk("R9 scl", scl_oe, 0);
    send_stop();
    repeat (4) @(negedge clk);
    chk("R11 nbb stop", nbb, 1); chk("R9 ext_stop", ext_stop, 0);
    ctrl_wr(4'b1111);

    // random transactions
    for (int t = 0; t < 8; t++) begin
      logic [6:0] a;
      logic rw;
      int len;
      a   = ($urandom % 2) ? OWN_A : OWN_B;
      rw  = 1'($urandom % 2);
      len = 1 + int'($urandom % 3);
      send_start();
      chk("R11 nbb", nbb, 0);
      write_byte(addr_byte(a, rw), ack);
      chk("R1 ack", ack, 1); chk("R1 aas", aas, 1); chk("R3 trx", trx, rw);
      chk("R4 stretch", {pend_n, scl_oe}, 2'b01);
      chk("R10 irq", irq, exp_irq(1'b1, pend_n, ber, ext_stop));
      if (!rw) begin
        sw_read(d);
        chk("R5 addr byte", d, addr_byte(a, rw));
        chk("R5 release", {pend_n, scl_oe}, 2'b10);
        for (int k = 0; k < len; k++) begin
          b = 8'($urandom);
          write_byte(b, ack);
          chk("R5 data ack", ack, 1);
          chk("R4 data stretch", {pend_n, scl_oe}, 2'b01);
          sw_read(d);
          chk("R5 data", d, b);
        end
      end else begin
        for (int k = 0; k < len; k++) begin
          logic last;
          last = (k == len - 1);
          b = 8'($urandom);
          sw_write(b);
          chk("R5 write clears", pend_n, 1);
          read_byte(!last, d);
          chk("R7 tx data", d, b);
          chk("R7 lrb", lrb, last);
          chk("R4 tx pend", pend_n, 0);
          chk("R7 tx stretch", scl_oe, !last);
        end
        sw_write(8'h00);
        chk("R7 dummy pend", pend_n, 1);
        chk("R7 dummy quiet", {scl_oe, sda_oe}, 0);
      end
      send_stop();
      repeat (4) @(negedge clk);
      chk("R11 nbb stop", nbb, 1); chk("R11 ext_stop", ext_stop, 1);
      ctrl_wr(4'b1111);
      @(negedge clk);
      chk("R8 ext_stop clear", ext_stop, 0);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule